// File: doc/BRIEF.md
# Disk Gap Sync Pattern Detector

This block sits behind the clock-recovery stage of a disk read path. It takes one decoded data bit per strobe and looks for the point where a byte-aligned field begins. Before a field the track carries a preamble of zero bytes that trains the recovery loop. That preamble ends with one fixed, asymmetric sync byte. The detector declares byte alignment only when the sync byte follows a zero run that is at least as long as the selected drive type requires. From then on it packs every eight valid bits into a parallel byte and marks each byte with a one-cycle strobe. It keeps doing so until the downstream field parser signals the end of the field.

A two-bit setting chooses the minimum preamble length. The setting covers ordinary count fields, the home-address field and two longer preambles used by other drive types. Runs of one bytes often come before the zero preamble, and these never produce alignment. Some fields are preceded by an address mark, which the recovery stage detects from missing clock pulses. For those fields the search can be held off until the recovery stage has reported that mark.

Top module: `gap_sync_detector`

## Requirements
- R1: While reset is asserted and after it is released, `locked` and `byte_vld` are 0 and `byte_out` is 0x00.
- R2: `locked` rises in the clock cycle after the valid bit that completes the sync byte. In arrival order the sync byte is 0,0,0,0,1,1,1,0. It must directly follow a qualifying zero run.
- R3: The zero run is qualifying when it holds at least 8×N zero bits before the four leading zeros of the sync byte. N is 4, 5, 7 or 9 for `vfo_sel` = 0, 1, 2 or 3. A shorter run gives no lock.
- R4: A one bit inside the zero run restarts the count. Only the zeros after the last one bit count toward N.
- R5: Runs of one bytes, or a byte that only resembles the sync byte (for example 0,0,0,0,1,1,1,1), never set `locked`.
- R6: While locked, every eighth valid bit produces `byte_vld` for exactly one cycle. `byte_out` holds the eight bits with the first-arrived bit in bit 7. `byte_out` changes only together with `byte_vld`.
- R7: Cycles with `bit_vld` low are ignored, whatever `bit_in` is. They neither advance the search nor the byte count, and `byte_vld` stays low in the next cycle.
- R8: A `field_end` pulse clears `locked` in the next cycle. It also discards a partly collected byte and clears any seen address mark. The next search starts with an empty zero run.
- R9: With `need_am` high, bits are not searched until an `am_flag` pulse has been seen since reset or the last `field_end`. With `need_am` low the mark is not needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a decoded bit this cycle |
| bit_in | input | 1 | Decoded data bit |
| am_flag | input | 1 | Pulse from clock recovery: address mark detected |
| need_am | input | 1 | 1 = the field must be preceded by an address mark |
| vfo_sel | input | 2 | Minimum preamble select (0:4, 1:5, 2:7, 3:9 zero bytes) |
| field_end | input | 1 | Pulse from the field parser: drop alignment |
| locked | output | 1 | Byte alignment established |
| byte_vld | output | 1 | One-cycle strobe for `byte_out` |
| byte_out | output | 8 | Assembled byte, first-arrived bit in bit 7 |

## Verification
Some properties hold on every cycle, and the assertions check those:
- alignment can only begin on a valid zero bit;
- `field_end` always drops lock;
- byte strobes occur only while locked, are isolated single pulses, never follow an idle cycle, and frame the only changes of `byte_out`.

Other behaviour depends on long bit histories, and only the bench scenarios can show it. This covers whether a given preamble length qualifies under each `vfo_sel` value, whether an embedded one bit restarts the run, whether near-miss patterns are rejected, and whether the address-mark gate holds off the search. The bench's reference model keeps the received bit history in a queue and judges each sync candidate against it.

// File: rtl/gsd_pkg.sv
`timescale 1ns/1ps
package gsd_pkg;
  localparam int BYTE_W = 8;
  // arrival order, first bit in bit 7
  localparam logic [BYTE_W-1:0] SYNC_WORD = 8'b0000_1110;
  // leading zeros of the sync word, counted into the zero run
  localparam int SYNC_LEAD_ZEROS = 4;

  typedef enum logic [1:0] {
    VFO_COUNT = 2'd0,
    VFO_HOME  = 2'd1,
    VFO_LONG  = 2'd2,
    VFO_XLONG = 2'd3
  } vfo_sel_e;
endpackage

// File: rtl/gsd_zero_run.sv
`timescale 1ns/1ps
// Counts consecutive zero bits; at the first one after a zero run it
// records whether that run met the threshold.
module gsd_zero_run #(
  parameter int RUN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             stb,
  input  logic             bit_in,
  input  logic [RUN_W-1:0] thresh,
  output logic             armed
);
  localparam logic [RUN_W-1:0] RUN_SAT = {RUN_W{1'b1}};

  logic [RUN_W-1:0] run_q, run_d;
  logic             armed_q, armed_d;

  always_comb begin
    run_d   = run_q;
    armed_d = armed_q;
    if (clr) begin
      run_d   = '0;
      armed_d = 1'b0;
    end else if (stb) begin
      if (bit_in) begin
        run_d = '0;
        if (run_q != '0) armed_d = (run_q >= thresh);
      end else if (run_q != RUN_SAT) begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;
endmodule

// File: rtl/gsd_pattern.sv
`timescale 1ns/1ps
// Shift window over the bit stream; flags the bit that completes PAT.
module gsd_pattern #(
  parameter int            W   = 8,
  parameter logic [W-1:0]  PAT = 8'b0000_1110
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic bit_in,
  output logic hit
);
  logic [W-1:0] win_q, win_d;
  logic [W-1:0] win_next;

  assign win_next = {win_q[W-2:0], bit_in};

  always_comb begin
    win_d = win_q;
    if (clr)      win_d = '0;
    else if (stb) win_d = win_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign hit = stb && !clr && (win_next == PAT);
endmodule

// File: rtl/gsd_assembler.sv
`timescale 1ns/1ps
// Serial-to-parallel packer: MSB first, one-cycle strobe per byte.
module gsd_assembler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         stb,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         vld
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     acc_q, acc_d;
  logic [W-1:0]     data_q, data_d;
  logic             vld_d, vld_q;

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    data_d = data_q;
    vld_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (stb) begin
      acc_d = {acc_q[W-2:0], bit_in};
      if (cnt_q == CNT_LAST) begin
        cnt_d  = '0;
        data_d = {acc_q[W-2:0], bit_in};
        vld_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign data = data_q;
  assign vld  = vld_q;
endmodule

// File: rtl/gap_sync_detector.sv
`timescale 1ns/1ps
module gap_sync_detector #(
  parameter int VFO_B0 = 4,
  parameter int VFO_B1 = 5,
  parameter int VFO_B2 = 7,
  parameter int VFO_B3 = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       am_flag,
  input  logic       need_am,
  input  logic [1:0] vfo_sel,
  input  logic       field_end,
  output logic       locked,
  output logic       byte_vld,
  output logic [7:0] byte_out
);
  import gsd_pkg::*;

  localparam int MAX_A   = (VFO_B0 > VFO_B1) ? VFO_B0 : VFO_B1;
  localparam int MAX_B   = (VFO_B2 > VFO_B3) ? VFO_B2 : VFO_B3;
  localparam int MAX_VFO = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int RUN_MAX = BYTE_W * MAX_VFO + BYTE_W;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int N_SEL   = 4;

  // threshold per selection: preamble zeros plus the sync word's leading zeros
  logic [RUN_W-1:0] thr_tab [N_SEL];
  for (genvar g = 0; g < N_SEL; g++) begin : g_thr
    localparam int NB = (g == 0) ? VFO_B0 : (g == 1) ? VFO_B1 :
                        (g == 2) ? VFO_B2 : VFO_B3;
    assign thr_tab[g] = RUN_W'(BYTE_W * NB + SYNC_LEAD_ZEROS);
  end

  vfo_sel_e         sel;
  logic [RUN_W-1:0] thresh;
  assign sel    = vfo_sel_e'(vfo_sel);
  assign thresh = thr_tab[sel];

  logic lock_q, lock_d;
  logic am_q, am_d;
  logic search_en, search_clr, search_stb;
  logic armed, pat_hit, sync_hit;
  logic asm_clr, asm_stb;

  assign search_en  = !lock_q && (!need_am || am_q);
  assign search_clr = field_end || !search_en;
  assign search_stb = bit_vld && search_en;

  gsd_zero_run #(.RUN_W(RUN_W)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (search_clr),
    .stb    (search_stb),
    .bit_in (bit_in),
    .thresh (thresh),
    .armed  (armed)
  );

  gsd_pattern #(.W(BYTE_W), .PAT(SYNC_WORD)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (search_clr),
    .stb    (search_stb),
    .bit_in (bit_in),
    .hit    (pat_hit)
  );

  assign sync_hit = pat_hit && armed;

  always_comb begin
    lock_d = lock_q;
    am_d   = am_q;
    if (field_end) begin
      lock_d = 1'b0;
      am_d   = 1'b0;
    end else begin
      if (sync_hit) lock_d = 1'b1;
      if (am_flag)  am_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      am_q   <= 1'b0;
    end else begin
      lock_q <= lock_d;
      am_q   <= am_d;
    end
  end

  assign asm_clr = field_end || !lock_q;
  assign asm_stb = bit_vld && lock_q;

  gsd_assembler #(.W(BYTE_W)) u_asm (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (asm_clr),
    .stb    (asm_stb),
    .bit_in (bit_in),
    .data   (byte_out),
    .vld    (byte_vld)
  );

  assign locked = lock_q;
endmodule

// File: rtl/gsd_checker.sv
`timescale 1ns/1ps
module gsd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_vld,
  input logic       bit_in,
  input logic       field_end,
  input logic       locked,
  input logic       byte_vld,
  input logic [7:0] byte_out
);
  p_lock_on_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(bit_vld) && !$past(bit_in)));

  p_end_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    field_end |=> !locked);

  p_vld_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> locked);

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> $stable(byte_out));

  p_idle_no_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !byte_vld);
endmodule

bind gap_sync_detector gsd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .bit_in    (bit_in),
  .field_end (field_end),
  .locked    (locked),
  .byte_vld  (byte_vld),
  .byte_out  (byte_out)
);

// File: tb/sim_gap_sync_detector.sv
`timescale 1ns/1ps
module sim_gap_sync_detector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_vld, bit_in, am_flag, need_am, field_end;
  logic [1:0] vfo_sel;
  logic       locked, byte_vld;
  logic [7:0] byte_out;

  int checks = 0;
  int failures = 0;
  bit gap = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  gap_sync_detector u0 (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .am_flag(am_flag), .need_am(need_am), .vfo_sel(vfo_sel),
    .field_end(field_end), .locked(locked), .byte_vld(byte_vld),
    .byte_out(byte_out)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int   vfo_tab [4] = '{4, 5, 7, 9};
  bit   hist[$];
  bit   m_lock, m_am, m_vld;
  bit [7:0] m_byte, m_acc;
  int   m_cnt;

  function automatic bit sync_seen();
    int n = 8 * vfo_tab[vfo_sel];
    int sz = hist.size();
    bit [7:0] sw = 8'b0000_1110;
    if (sz < n + 8) return 0;
    for (int i = 0; i < 8; i++)
      if (hist[sz-8+i] != sw[7-i]) return 0;
    for (int i = sz - 8 - n; i < sz - 8; i++)
      if (hist[i] != 1'b0) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit am_old;
    if (!rst_n) begin
      m_lock = 0; m_am = 0; m_vld = 0; m_byte = 0; m_acc = 0; m_cnt = 0;
      hist.delete();
    end else begin
      am_old = m_am;
      m_vld = 0;
      if (field_end) begin
        m_lock = 0; m_am = 0; m_cnt = 0;
        hist.delete();
      end else begin
        if (am_flag) m_am = 1;
        if (m_lock) begin
          if (bit_vld) begin
            m_acc = {m_acc[6:0], bit_in};
            m_cnt++;
            if (m_cnt == 8) begin
              m_byte = m_acc; m_vld = 1; m_cnt = 0;
            end
          end
        end else if (!need_am || am_old) begin
          if (bit_vld) begin
            hist.push_back(bit_in);
            if (hist.size() > 120) void'(hist.pop_front());
            if (sync_seen()) begin
              m_lock = 1; m_cnt = 0; hist.delete();
            end
          end
        end else begin
          hist.delete();
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic [7:0] got[$];
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R2 locked vs model", int'(locked), int'(m_lock));
      check("R6 byte_vld vs model", int'(byte_vld), int'(m_vld));
      check("R6 byte_out vs model", int'(byte_out), int'(m_byte));
    end
    if (rst_n && byte_vld) got.push_back(byte_out);
  end

  // ---------------- stimulus ----------------
  task automatic put_bit(bit b);
    bit_vld = 1; bit_in = b;
    @(negedge clk);
    bit_vld = 0; bit_in = ~b;     // idle cycles carry garbage (R7)
    if (gap) @(negedge clk);
  endtask

  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic put_zeros(int n);
    repeat (n) put_byte(8'h00);
  endtask

  task automatic end_field();
    field_end = 1;
    @(negedge clk);
    field_end = 0;
    check("R8 unlocked after field_end", int'(locked), 0);
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R2 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; bit_vld = 0; bit_in = 0; am_flag = 0; need_am = 0;
    vfo_sel = 2'd0; field_end = 0;
    repeat (3) @(negedge clk);
    check("R1 locked in reset", int'(locked), 0);
    check("R1 byte_vld in reset", int'(byte_vld), 0);
    check("R1 byte_out in reset", int'(byte_out), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 locked after reset", int'(locked), 0);
    cmp_on = 1;

    // R2/R5/R6: ones bytes, 4 zero bytes, sync, data
    put_byte(8'hFF); put_byte(8'hFF);
    check("R5 ones bytes no lock", int'(locked), 0);
    put_zeros(4); put_byte(8'h0E);
    check("R2 lock after sync", int'(locked), 1);
    got.delete();
    put_byte(8'hA5); put_byte(8'h3C);
    settle();
    check("R6 byte count", got.size(), 2);
    if (got.size() == 2) begin
      check("R6 first byte", int'(got[0]), 8'hA5);
      check("R6 second byte", int'(got[1]), 8'h3C);
    end
    end_field();

    // R3: too short for selection 0
    put_zeros(3); put_byte(8'h0E);
    check("R3 short run no lock sel0", int'(locked), 0);
    end_field();

    // R3: selection 1 exact length
    vfo_sel = 2'd1;
    put_zeros(4); put_byte(8'h0E);
    check("R3 4 bytes no lock sel1", int'(locked), 0);
    end_field();
    put_zeros(5); put_byte(8'h0E);
    check("R3 5 bytes lock sel1", int'(locked), 1);
    end_field();

    // R3: selection 2 and 3
    vfo_sel = 2'd2;
    put_zeros(7); put_byte(8'h0E);
    check("R3 7 bytes lock sel2", int'(locked), 1);
    end_field();
    vfo_sel = 2'd3;
    put_zeros(8); put_byte(8'h0E);
    check("R3 8 bytes no lock sel3", int'(locked), 0);
    end_field();
    put_zeros(9); put_byte(8'h0E);
    check("R3 9 bytes lock sel3", int'(locked), 1);
    end_field();

    // R4: one bit inside the run restarts the count
    vfo_sel = 2'd0;
    put_zeros(3); put_byte(8'h10); put_zeros(3); put_byte(8'h0E);
    check("R4 broken run no lock", int'(locked), 0);
    put_zeros(4); put_byte(8'h0E);
    check("R4 fresh run locks", int'(locked), 1);
    end_field();

    // R5: near-miss pattern
    put_zeros(4); put_byte(8'h0F);
    check("R5 near miss no lock", int'(locked), 0);
    put_byte(8'hFF); put_byte(8'h0E);
    check("R5 sync after ones no lock", int'(locked), 0);
    end_field();

    // R7: idle cycles with garbage between bits
    gap = 1;
    put_zeros(4); put_byte(8'h0E);
    check("R7 lock with idle gaps", int'(locked), 1);
    got.delete();
    put_byte(8'h96);
    settle();
    check("R7 byte count with gaps", got.size(), 1);
    if (got.size() == 1) check("R7 byte with gaps", int'(got[0]), 8'h96);
    gap = 0;
    end_field();

    // R8: field_end mid-byte drops the partial byte
    put_zeros(4); put_byte(8'h0E);
    got.delete();
    put_bit(1); put_bit(1); put_bit(0); put_bit(1);
    end_field();
    put_zeros(4); put_byte(8'h0E); put_byte(8'h5A);
    settle();
    check("R8 partial byte discarded count", got.size(), 1);
    if (got.size() == 1) check("R8 new byte after relock", int'(got[0]), 8'h5A);
    end_field();

    // R9: address-mark gate
    need_am = 1;
    put_zeros(4); put_byte(8'h0E);
    check("R9 no lock without mark", int'(locked), 0);
    end_field();
    am_flag = 1; @(negedge clk); am_flag = 0;
    put_zeros(4); put_byte(8'h0E);
    check("R9 lock after mark", int'(locked), 1);
    got.delete();
    put_byte(8'hC3);
    settle();
    check("R9 byte count", got.size(), 1);
    if (got.size() == 1) check("R9 byte after mark", int'(got[0]), 8'hC3);
    end_field();
    put_zeros(4); put_byte(8'h0E);
    check("R9 mark cleared by field_end", int'(locked), 0);
    end_field();

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule